// File: doc/BRIEF.md
# Prioritised interrupt level resolver

This block gathers interrupt requests from many sources. The sources are grouped into numbered priority levels. For each level the block keeps a pending mask with one bit per source. It also keeps one status bit per level, which says that something was posted to that level. The status word is combined with a software request vector. From the two, the block derives a single active priority level and a summary mask. The summary mask has one bit for every contributor. An interrupt request goes out when that level beats the current priority threshold and the program counter is word aligned.

Commands arrive as one-cycle strobes with a level number and a source index: post, clear and clear-all. The resolved level and summary are not handed out at once. An acknowledge strobe captures them into a holding register. A later commit strobe publishes the captured pair on the outputs with a one-cycle valid pulse. This lets the consumer take the interrupt first and update its state afterwards.

Top module: `irq_level_resolver`

## Requirements
- R1: A post whose level and index are in range sets that source bit in that level's pending mask, and it sets the level's status bit on the same clock edge.
- R2: A clear whose level and index are in range removes that source bit. The level's status bit drops only when no other source bit of the level remains set.
- R3: Clear-all empties every pending mask and the whole status word on one edge. When several strobes are asserted in the same cycle, clear-all takes precedence over clear, and clear takes precedence over post.
- R4: No request is raised while the status word is all zero, whatever the software request vector holds.
- R5: No request is raised while PC bit 0 or PC bit 1 is 1.
- R6: A software request bit i with SW_MIN <= i < SW_MAX gives candidate level i-SW_MIN+1. The highest such set bit gives the software candidate.
- R7: An active status bit i with EXT_MIN <= i < EXT_MAX gives level i. If any such level is active, the highest one replaces the software candidate, whatever the software value.
- R8: The summary has bit i set for every contributing software bit and every contributing external level, each at its own bit position. Status bits outside the external range never appear in the summary.
- R9: irq_o is 1 only when the resolved level is nonzero and strictly greater than cur_ipl. It is registered, so it shows the state and inputs of the previous edge.
- R10: ack captures the resolved level and summary and marks the capture as held. A later commit drives them onto pub_level_o and pub_summary_o, pulses pub_valid_o for one cycle and releases the hold. Changes made between ack and commit do not alter the published values.
- R11: A commit with no held capture sets the sticky commit_err_o. It produces no pub_valid_o pulse and leaves the published values unchanged.
- R12: A post or clear with level >= NUM_LEVELS or index >= NSRC changes no state and sets the sticky cmd_err_o.
- R13: Synchronous reset clears all masks, the status word, the hold flag, both error flags, irq_o and pub_valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_post | input | 1 | Post strobe |
| cmd_clear | input | 1 | Clear strobe |
| cmd_clear_all | input | 1 | Clear-all strobe |
| cmd_level | input | $clog2(NUM_LEVELS)+1 | Addressed level |
| cmd_index | input | $clog2(NSRC)+1 | Addressed source within the level |
| sw_req | input | NUM_LEVELS | Software request vector |
| cur_ipl | input | $clog2(NUM_LEVELS) | Current priority threshold |
| pc | input | PC_W | Program counter |
| ack | input | 1 | Capture the resolved level and summary |
| commit | input | 1 | Publish the captured pair |
| irq_o | output | 1 | Registered interrupt request |
| cmd_err_o | output | 1 | Sticky flag for an out-of-range command |
| pub_level_o | output | $clog2(NUM_LEVELS) | Published level |
| pub_summary_o | output | NUM_LEVELS | Published summary |
| pub_valid_o | output | 1 | One-cycle pulse when a pair is published |
| commit_err_o | output | 1 | Sticky flag for a commit with nothing held |

## Verification
The bench attacks the two-tier clear. It posts two sources on one level and removes them one at a time. A design that dropped the status bit on the first clear would lose the level early. The bench also sets software bits while only a level above the external range is posted. A design that gated on the resolved level alone, or leaked that level into the summary, would report the wrong level or the wrong mask. Further cases are the PC low bits one at a time, a threshold equal to the level, which must not fire, and state changes between ack and commit, which must not change what is published. Out-of-range commands must leave no trace, and a commit with nothing held must flag an error rather than publish stale data.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    CMD_NONE      = 2'd0,
    CMD_POST      = 2'd1,
    CMD_CLEAR     = 2'd2,
    CMD_CLEAR_ALL = 2'd3
  } cmd_kind_e;
endpackage

// File: rtl/irq_pend_store.sv
module irq_pend_store import irq_pkg::*; #(
  parameter int NUM_LEVELS = 32,
  parameter int NSRC       = 8,
  parameter int CMD_LVL_W  = $clog2(NUM_LEVELS) + 1,
  parameter int CMD_IDX_W  = $clog2(NSRC) + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  cmd_kind_e             kind,
  input  logic [CMD_LVL_W-1:0]  lvl,
  input  logic [CMD_IDX_W-1:0]  idx,
  output logic [NUM_LEVELS-1:0] status_o,
  output logic                  cmd_err_o
);
  localparam int LVL_W = $clog2(NUM_LEVELS);
  localparam int IDX_W = $clog2(NSRC);

  logic [NSRC-1:0] pend_q [NUM_LEVELS];
  logic [NUM_LEVELS-1:0] status_q;
  logic err_q;

  logic in_range;
  logic [LVL_W-1:0] lvl_s;
  logic [IDX_W-1:0] idx_s;
  logic [NSRC-1:0] src_bit;
  logic [NSRC-1:0] rest_mask;

  always_comb begin
    in_range  = (int'(lvl) < NUM_LEVELS) && (int'(idx) < NSRC);
    lvl_s     = lvl[LVL_W-1:0];
    idx_s     = idx[IDX_W-1:0];
    src_bit   = NSRC'(1) << idx_s;
    rest_mask = in_range ? (pend_q[lvl_s] & ~src_bit) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_LEVELS; k++) pend_q[k] <= '0;
      status_q <= '0;
      err_q    <= 1'b0;
    end else begin
      case (kind)
        CMD_CLEAR_ALL: begin
          for (int k = 0; k < NUM_LEVELS; k++) pend_q[k] <= '0;
          status_q <= '0;
        end
        CMD_POST: begin
          if (in_range) begin
            pend_q[lvl_s]   <= pend_q[lvl_s] | src_bit;
            status_q[lvl_s] <= 1'b1;
          end else begin
            err_q <= 1'b1;
          end
        end
        CMD_CLEAR: begin
          if (in_range) begin
            pend_q[lvl_s] <= rest_mask;
            if (rest_mask == '0) status_q[lvl_s] <= 1'b0;
          end else begin
            err_q <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign status_o  = status_q;
  assign cmd_err_o = err_q;

  // R1: an accepted post leaves its level marked active
  p_post_marks_r1: assert property (@(posedge clk) disable iff (rst)
    (kind == CMD_POST && in_range) |=> status_q[$past(lvl_s)]);

  // R3: clear-all empties the status word on one edge
  p_clear_all_r3: assert property (@(posedge clk) disable iff (rst)
    (kind == CMD_CLEAR_ALL) |=> (status_q == '0));

  // R12: error flag is sticky
  p_err_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);

  // R12: rejected commands leave the status word untouched
  p_reject_no_change_r12: assert property (@(posedge clk) disable iff (rst)
    ((kind == CMD_POST || kind == CMD_CLEAR) && !in_range) |=> $stable(status_q));
endmodule

// File: rtl/irq_prio_eval.sv
module irq_prio_eval #(
  parameter int NUM_LEVELS = 32,
  parameter int SW_MIN     = 1,
  parameter int SW_MAX     = 16,
  parameter int EXT_MIN    = 16,
  parameter int EXT_MAX    = 31
) (
  input  logic [NUM_LEVELS-1:0]         status_i,
  input  logic [NUM_LEVELS-1:0]         sw_req_i,
  output logic [$clog2(NUM_LEVELS)-1:0] lvl_o,
  output logic [NUM_LEVELS-1:0]         sum_o
);
  localparam int LVL_W = $clog2(NUM_LEVELS);

  function automatic logic [NUM_LEVELS-1:0] range_mask(int lo, int hi);
    logic [NUM_LEVELS-1:0] m;
    m = '0;
    for (int b = 0; b < NUM_LEVELS; b++) if (b >= lo && b < hi) m[b] = 1'b1;
    return m;
  endfunction

  localparam logic [NUM_LEVELS-1:0] SW_MASK  = range_mask(SW_MIN, SW_MAX);
  localparam logic [NUM_LEVELS-1:0] EXT_MASK = range_mask(EXT_MIN, EXT_MAX);

  logic [NUM_LEVELS-1:0] sw_m, ext_m;

  always_comb begin
    sw_m  = sw_req_i & SW_MASK;
    ext_m = status_i & EXT_MASK;
    lvl_o = '0;
    sum_o = '0;
    // software tier first, offset into its own priority range
    for (int i = 0; i < NUM_LEVELS; i++) begin
      if (sw_m[i]) begin
        lvl_o    = LVL_W'(i - SW_MIN + 1);
        sum_o[i] = 1'b1;
      end
    end
    // external tier overrides any software candidate
    for (int i = 0; i < NUM_LEVELS; i++) begin
      if (ext_m[i]) begin
        lvl_o    = LVL_W'(i);
        sum_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_info_latch.sv
module irq_info_latch #(
  parameter int NUM_LEVELS = 32,
  parameter int LVL_W      = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ack,
  input  logic                  commit,
  input  logic [LVL_W-1:0]      lvl_i,
  input  logic [NUM_LEVELS-1:0] sum_i,
  output logic [LVL_W-1:0]      pub_level_o,
  output logic [NUM_LEVELS-1:0] pub_summary_o,
  output logic                  pub_valid_o,
  output logic                  commit_err_o
);
  logic [LVL_W-1:0]      held_lvl_q;
  logic [NUM_LEVELS-1:0] held_sum_q;
  logic                  held_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_lvl_q    <= '0;
      held_sum_q    <= '0;
      held_q        <= 1'b0;
      pub_level_o   <= '0;
      pub_summary_o <= '0;
      pub_valid_o   <= 1'b0;
      commit_err_o  <= 1'b0;
    end else begin
      pub_valid_o <= 1'b0;
      if (commit) begin
        if (held_q) begin
          pub_level_o   <= held_lvl_q;
          pub_summary_o <= held_sum_q;
          pub_valid_o   <= 1'b1;
          held_q        <= 1'b0;
        end else begin
          commit_err_o <= 1'b1;
        end
      end
      if (ack) begin
        held_lvl_q <= lvl_i;
        held_sum_q <= sum_i;
        held_q     <= 1'b1;
      end
    end
  end

  // R10: a publication pulse only follows a commit that found a held capture
  p_pub_after_commit_r10: assert property (@(posedge clk) disable iff (rst)
    pub_valid_o |-> ($past(commit) && $past(held_q)));

  // R11: commit with nothing held raises the sticky error
  p_commit_err_r11: assert property (@(posedge clk) disable iff (rst)
    (commit && !held_q) |=> commit_err_o);

  // R11: published values hold without a pulse
  p_pub_stable_r11: assert property (@(posedge clk) disable iff (rst)
    !pub_valid_o |-> ($stable(pub_level_o) && $stable(pub_summary_o)));
endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver import irq_pkg::*; #(
  parameter int NUM_LEVELS = 32,
  parameter int NSRC       = 8,
  parameter int SW_MIN     = 1,
  parameter int SW_MAX     = 16,
  parameter int EXT_MIN    = 16,
  parameter int EXT_MAX    = 31,
  parameter int PC_W       = 32,
  localparam int LVL_W     = $clog2(NUM_LEVELS),
  localparam int CMD_LVL_W = LVL_W + 1,
  localparam int CMD_IDX_W = $clog2(NSRC) + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmd_post,
  input  logic                  cmd_clear,
  input  logic                  cmd_clear_all,
  input  logic [CMD_LVL_W-1:0]  cmd_level,
  input  logic [CMD_IDX_W-1:0]  cmd_index,
  input  logic [NUM_LEVELS-1:0] sw_req,
  input  logic [LVL_W-1:0]      cur_ipl,
  input  logic [PC_W-1:0]       pc,
  input  logic                  ack,
  input  logic                  commit,
  output logic                  irq_o,
  output logic                  cmd_err_o,
  output logic [LVL_W-1:0]      pub_level_o,
  output logic [NUM_LEVELS-1:0] pub_summary_o,
  output logic                  pub_valid_o,
  output logic                  commit_err_o
);
  localparam logic [PC_W-1:0] PC_ALIGN_MASK = PC_W'(3);

  cmd_kind_e             kind;
  logic [NUM_LEVELS-1:0] status;
  logic [LVL_W-1:0]      res_lvl;
  logic [NUM_LEVELS-1:0] res_sum;
  logic                  pc_aligned;
  logic                  irq_d, irq_q;

  always_comb begin
    if (cmd_clear_all)  kind = CMD_CLEAR_ALL;
    else if (cmd_clear) kind = CMD_CLEAR;
    else if (cmd_post)  kind = CMD_POST;
    else                kind = CMD_NONE;
  end

  irq_pend_store #(
    .NUM_LEVELS(NUM_LEVELS), .NSRC(NSRC),
    .CMD_LVL_W(CMD_LVL_W), .CMD_IDX_W(CMD_IDX_W)
  ) u_store (
    .clk(clk), .rst(rst), .kind(kind), .lvl(cmd_level), .idx(cmd_index),
    .status_o(status), .cmd_err_o(cmd_err_o)
  );

  irq_prio_eval #(
    .NUM_LEVELS(NUM_LEVELS), .SW_MIN(SW_MIN), .SW_MAX(SW_MAX),
    .EXT_MIN(EXT_MIN), .EXT_MAX(EXT_MAX)
  ) u_eval (
    .status_i(status), .sw_req_i(sw_req), .lvl_o(res_lvl), .sum_o(res_sum)
  );

  irq_info_latch #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_info (
    .clk(clk), .rst(rst), .ack(ack), .commit(commit),
    .lvl_i(res_lvl), .sum_i(res_sum),
    .pub_level_o(pub_level_o), .pub_summary_o(pub_summary_o),
    .pub_valid_o(pub_valid_o), .commit_err_o(commit_err_o)
  );

  always_comb begin
    pc_aligned = ((pc & PC_ALIGN_MASK) == '0);
    irq_d = (status != '0) && pc_aligned && (res_lvl != '0) && (res_lvl > cur_ipl);
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  // R4: empty status word blocks the request
  p_no_status_r4: assert property (@(posedge clk) disable iff (rst)
    (status == '0) |=> !irq_q);

  // R5: misaligned PC blocks the request
  p_pc_gate_r5: assert property (@(posedge clk) disable iff (rst)
    ((pc & PC_ALIGN_MASK) != '0) |=> !irq_q);

  // R9: a level at or below the threshold never fires
  p_strict_r9: assert property (@(posedge clk) disable iff (rst)
    (res_lvl <= cur_ipl) |=> !irq_q);
endmodule

// File: tb/irq_level_resolver_test.sv
module irq_level_resolver_test;
  localparam int NL = 32;
  localparam int NS = 8;
  localparam int SWMIN = 1, SWMAX = 16, EXTMIN = 16, EXTMAX = 31;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_post = 0, cmd_clear = 0, cmd_clear_all = 0;
  logic [5:0] cmd_level = '0;
  logic [3:0] cmd_index = '0;
  logic [NL-1:0] sw_req = '0;
  logic [4:0] cur_ipl = '0;
  logic [31:0] pc = '0;
  logic ack = 0, commit = 0;
  logic irq_o, cmd_err_o, pub_valid_o, commit_err_o;
  logic [4:0] pub_level_o;
  logic [NL-1:0] pub_summary_o;

  irq_level_resolver uut (
    .clk(clk), .rst(rst), .cmd_post(cmd_post), .cmd_clear(cmd_clear),
    .cmd_clear_all(cmd_clear_all), .cmd_level(cmd_level), .cmd_index(cmd_index),
    .sw_req(sw_req), .cur_ipl(cur_ipl), .pc(pc), .ack(ack), .commit(commit),
    .irq_o(irq_o), .cmd_err_o(cmd_err_o), .pub_level_o(pub_level_o),
    .pub_summary_o(pub_summary_o), .pub_valid_o(pub_valid_o),
    .commit_err_o(commit_err_o)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  logic [NS-1:0] m_pend [NL];
  logic [NL-1:0] m_stat;
  logic [4:0] exp_lvl_q [$];
  logic [NL-1:0] exp_sum_q [$];
  string exp_tag_q [$];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model of the level and summary, from the requirements
  function automatic void ref_eval(output logic [4:0] lv, output logic [NL-1:0] sm);
    lv = '0; sm = '0;
    for (int i = SWMIN; i < SWMAX; i++) if (sw_req[i]) begin lv = 5'(i - SWMIN + 1); sm[i] = 1; end
    for (int i = EXTMIN; i < EXTMAX; i++) if (m_stat[i]) begin lv = 5'(i); sm[i] = 1; end
  endfunction

  function automatic bit ref_irq();
    logic [4:0] lv; logic [NL-1:0] sm;
    ref_eval(lv, sm);
    return (m_stat != 0) && (pc[1:0] == 0) && (lv != 0) && (lv > cur_ipl);
  endfunction

  task automatic settle(); repeat (2) @(negedge clk); endtask

  task automatic do_cmd(input int kind, input int lvl, input int idx);
    @(negedge clk);
    cmd_level = 6'(lvl); cmd_index = 4'(idx);
    cmd_post = (kind == 1); cmd_clear = (kind == 2); cmd_clear_all = (kind == 3);
    if (kind == 3) begin
      for (int k = 0; k < NL; k++) m_pend[k] = '0;
      m_stat = '0;
    end else if (lvl < NL && idx < NS) begin
      if (kind == 1) begin m_pend[lvl][idx] = 1; m_stat[lvl] = 1; end
      else begin m_pend[lvl][idx] = 0; if (m_pend[lvl] == 0) m_stat[lvl] = 0; end
    end
    @(negedge clk);
    cmd_post = 0; cmd_clear = 0; cmd_clear_all = 0;
    @(negedge clk);
  endtask

  task automatic do_ack(input string tag);
    logic [4:0] lv; logic [NL-1:0] sm;
    @(negedge clk);
    ref_eval(lv, sm);
    exp_lvl_q.push_back(lv); exp_sum_q.push_back(sm); exp_tag_q.push_back(tag);
    ack = 1;
    @(negedge clk);
    ack = 0;
  endtask

  task automatic do_commit();
    @(negedge clk); commit = 1;
    @(negedge clk); commit = 0;
    @(negedge clk);
  endtask

  task automatic check_irq(input string tag);
    bit e;
    settle();
    e = ref_irq();
    check(irq_o === e, tag, longint'(irq_o), longint'(e));
  endtask

  // monitor: every publication pulse is matched against the scoreboard
  always @(negedge clk) begin
    if (!rst && pub_valid_o) begin
      if (exp_lvl_q.size() == 0) begin
        check(0, "R11 unexpected publication", longint'(pub_level_o), 0);
      end else begin
        logic [4:0] el; logic [NL-1:0] es; string t;
        el = exp_lvl_q.pop_front(); es = exp_sum_q.pop_front(); t = exp_tag_q.pop_front();
        check(pub_level_o === el, {t, " level"}, longint'(pub_level_o), longint'(el));
        check(pub_summary_o === es, {t, " summary"}, longint'(pub_summary_o), longint'(es));
      end
    end
  end

  initial begin
    #1500000;
    check(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < NL; k++) m_pend[k] = '0;
    m_stat = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R13 reset state
    check(irq_o === 0, "R13 irq after reset", longint'(irq_o), 0);
    check(cmd_err_o === 0, "R13 cmd_err after reset", longint'(cmd_err_o), 0);
    check(commit_err_o === 0, "R13 commit_err after reset", longint'(commit_err_o), 0);
    check(pub_valid_o === 0, "R13 pub_valid after reset", longint'(pub_valid_o), 0);

    // R11 commit with nothing held
    do_commit();
    check(commit_err_o === 1, "R11 commit without ack", longint'(commit_err_o), 1);
    check(pub_level_o === 0, "R11 published level unchanged", longint'(pub_level_o), 0);

    // R1 post external level 20
    do_cmd(1, 20, 3);
    check_irq("R1 post raises irq");
    check(irq_o === 1, "R1 irq level 20", longint'(irq_o), 1);

    // R5 PC gate, each low bit
    pc = 32'h1002; check_irq("R5 pc bit1");
    check(irq_o === 0, "R5 pc bit1 blocks", longint'(irq_o), 0);
    pc = 32'h1001; check_irq("R5 pc bit0");
    pc = 32'h1000; check_irq("R5 aligned pc");

    // R9 strict compare
    cur_ipl = 20; check_irq("R9 ipl equal");
    check(irq_o === 0, "R9 equal blocks", longint'(irq_o), 0);
    cur_ipl = 19; check_irq("R9 ipl below");
    check(irq_o === 1, "R9 below fires", longint'(irq_o), 1);
    cur_ipl = 0;

    // R2 two sources on one level, clear one at a time
    do_cmd(1, 20, 5);
    do_cmd(2, 20, 3);
    check_irq("R2 one source left");
    check(irq_o === 1, "R2 level kept", longint'(irq_o), 1);
    do_ack("R2 level still 20");
    do_commit();
    do_cmd(2, 20, 5);
    check_irq("R2 last source cleared");
    check(irq_o === 0, "R2 level dropped", longint'(irq_o), 0);

    // R4 software only, status empty
    sw_req = 32'h0000_0020;
    check_irq("R4 sw without status");
    check(irq_o === 0, "R4 blocked", longint'(irq_o), 0);

    // R12 out of range commands ignored
    do_cmd(1, 40, 0);
    check(cmd_err_o === 1, "R12 level out of range flags", longint'(cmd_err_o), 1);
    do_cmd(1, 20, 9);
    check_irq("R12 bad index ignored");
    check(irq_o === 0, "R12 no status from bad index", longint'(irq_o), 0);

    // R6 R8: status only above ext range, software decides
    do_cmd(1, 31, 0);
    check_irq("R6 sw level with level31 status");
    check(irq_o === 1, "R6 fires with sw level 5", longint'(irq_o), 1);
    do_ack("R6 sw level 5, R8 no bit 31");
    do_commit();
    sw_req = 32'h0000_0408; check_irq("R6 highest sw bit");
    do_ack("R6 highest sw bit 10");
    do_commit();

    // R7 R8: external overrides, summary mixes tiers
    do_cmd(1, 17, 2);
    check_irq("R7 ext 17");
    do_ack("R7 ext level 17, R8 mixed summary");
    do_commit();
    sw_req = 32'h0000_8000; do_cmd(1, 16, 1);
    do_ack("R7 ext 17 over sw 15 and ext 16");
    do_commit();

    // R10 deferred publish, then R3 clear-all in between
    do_ack("R10 captured before clear-all");
    do_cmd(3, 0, 0);
    check_irq("R3 clear-all");
    check(irq_o === 0, "R3 all cleared", longint'(irq_o), 0);
    do_commit();

    // R3 clear-all wins over simultaneous post
    @(negedge clk);
    cmd_post = 1; cmd_clear_all = 1; cmd_level = 6'd22; cmd_index = 4'd0;
    @(negedge clk);
    cmd_post = 0; cmd_clear_all = 0;
    check_irq("R3 clear-all priority");
    check(irq_o === 0, "R3 post discarded", longint'(irq_o), 0);

    repeat (4) @(negedge clk);
    check(exp_lvl_q.size() == 0, "R10 all captures published", exp_lvl_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule